// File: doc/BRIEF.md
# Byte-Lane Write Decoder with Flow-Through SRAM Array

This block is the write path and storage of a small synchronous static RAM whose data word is split into four byte lanes. Every control, address and data input is captured on the rising clock edge. The captured controls are decoded into one write strobe per lane. Those strobes then update a behavioural memory array at the following rising edge, so no write pulse is needed from outside.

There are three active-low write controls. A global write forces every lane to be written. A per-lane write input only counts while a separate lane-enable input is also low. With the default 9-bit lanes (36-bit word), the ninth bit of each lane is the parity bit of its byte and is written along with it. The same parameters also give a 32-bit word with 8-bit lanes.

Reads are flow-through. In any cycle whose captured controls request no write, the output presents the word at the captured address in that same cycle. A drive-enable output tells the surrounding pad logic when it may place the output on the shared data bus. It is dropped in write cycles so that the bus can carry incoming data.

Top module: `lane_write_sram`

## Requirements
- R1: Lane i occupies word bits [i*LANE_W +: LANE_W]; with the global write high and the lane enable low, `lane_wr_n[i]` low writes lane i and `lane_wr_n[i]` high leaves lane i unchanged (lane 0 is the least significant).
- R2: With `wr_all_n` low, every lane is written with the captured data, whatever `lane_en_n` and `lane_wr_n` are.
- R3: With `wr_all_n` high and `lane_en_n` high, no lane is written, whatever `lane_wr_n` is.
- R4: A single cycle may write any set of one to four lanes, and lanes outside the set keep their earlier content.
- R5: Inputs are captured at a rising edge and the array is updated at the next rising edge, so a read of the same address captured at that next edge already returns the new word.
- R6: In a cycle whose captured controls request no write, `q_out` equals the stored word at the captured address and `q_drive` is 1.
- R7: In a cycle whose captured controls request a write to at least one lane, `q_drive` is 0.
- R8: A synchronous active-high reset clears the captured controls, so no lane is written and `q_drive` is 1 after it; write requests presented during reset are dropped and the array keeps its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, captured each edge |
| wr_all_n | input | 1 | Global write, active low, writes every lane |
| lane_en_n | input | 1 | Lane enable, active low, qualifies `lane_wr_n` |
| lane_wr_n | input | NUM_LANES | Per-lane write, active low, bit i selects lane i |
| d_in | input | NUM_LANES*LANE_W | Write data from the shared bus |
| q_out | output | NUM_LANES*LANE_W | Flow-through read data |
| q_drive | output | 1 | High when `q_out` may drive the shared bus |

## Verification
A request captured at edge N gives its `q_drive` value right after edge N, and its array update lands at edge N+1. A read captured at edge N shows its word on `q_out` right after edge N. The bench drives each operation on a falling edge and checks it on the next falling edge, which lies between the capture edge and the update edge. A read that directly follows a write therefore sees the written word exactly one cycle later, as R5 requires. The assertions compare the strobes in each cycle with the control inputs presented one edge earlier.

// File: rtl/lws_pkg.sv
package lws_pkg;

  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } lws_cyc_e;

  typedef struct packed {
    logic all_n;
    logic en_n;
  } lws_gate_t;

  localparam lws_gate_t GATE_IDLE = '{all_n: 1'b1, en_n: 1'b1};

endpackage

// File: rtl/lws_ctrl_reg.sv
module lws_ctrl_reg
  import lws_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  lws_gate_t            gate_in,
  input  logic [NUM_LANES-1:0] lane_n,
  input  logic [DATA_W-1:0]    d_in,
  output logic [ADDR_W-1:0]    addr_q,
  output lws_gate_t            gate_q,
  output logic [NUM_LANES-1:0] lane_n_q,
  output logic [DATA_W-1:0]    data_q
);

  // controls and address: cleared to idle by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      gate_q   <= GATE_IDLE;
      lane_n_q <= '1;
    end else begin
      addr_q   <= addr;
      gate_q   <= gate_in;
      lane_n_q <= lane_n;
    end
  end

  // data path carries no reset
  always_ff @(posedge clk) begin
    data_q <= d_in;
  end

endmodule

// File: rtl/lws_strobe_dec.sv
module lws_strobe_dec
  import lws_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  lws_gate_t            gate,
  input  logic [NUM_LANES-1:0] lane_n,
  output logic [NUM_LANES-1:0] stb,
  output lws_cyc_e             kind
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign stb[i] = !gate.all_n || (!gate.en_n && !lane_n[i]);
  end

  assign kind = (|stb) ? CYC_WRITE : CYC_READ;

endmodule

// File: rtl/lws_lane_ram.sv
module lws_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // address is already registered upstream: flow-through read
  assign rdata = mem[addr];

endmodule

// File: rtl/lane_write_sram.sv
module lane_write_sram
  import lws_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_all_n,
  input  logic                 lane_en_n,
  input  logic [NUM_LANES-1:0] lane_wr_n,
  input  logic [DATA_W-1:0]    d_in,
  output logic [DATA_W-1:0]    q_out,
  output logic                 q_drive
);

  lws_gate_t            gate_in;
  lws_gate_t            gate_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_LANES-1:0] lane_n_q;
  logic [DATA_W-1:0]    data_q;
  logic [NUM_LANES-1:0] lane_stb;
  lws_cyc_e             cyc_kind;

  assign gate_in = '{all_n: wr_all_n, en_n: lane_en_n};

  lws_ctrl_reg #(
    .ADDR_W   (ADDR_W),
    .NUM_LANES(NUM_LANES),
    .DATA_W   (DATA_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .gate_in (gate_in),
    .lane_n  (lane_wr_n),
    .d_in    (d_in),
    .addr_q  (addr_q),
    .gate_q  (gate_q),
    .lane_n_q(lane_n_q),
    .data_q  (data_q)
  );

  lws_strobe_dec #(
    .NUM_LANES(NUM_LANES)
  ) dec_i (
    .gate  (gate_q),
    .lane_n(lane_n_q),
    .stb   (lane_stb),
    .kind  (cyc_kind)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_ram
    lws_lane_ram #(
      .ADDR_W(ADDR_W),
      .LANE_W(LANE_W)
    ) ram_i (
      .clk  (clk),
      .we   (lane_stb[i]),
      .addr (addr_q),
      .wdata(data_q[i*LANE_W +: LANE_W]),
      .rdata(q_out[i*LANE_W +: LANE_W])
    );
  end

  assign q_drive = (cyc_kind == CYC_READ);

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_all_n,
  input logic                 lane_en_n,
  input logic [NUM_LANES-1:0] lane_wr_n,
  input logic [NUM_LANES-1:0] lane_stb,
  input logic                 q_drive
);

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(wr_all_n)) |-> (&lane_stb)); // R2

  AST_LANE_ONE_TO_ONE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(wr_all_n) && !$past(lane_en_n)) |-> (lane_stb == ~$past(lane_wr_n))); // R1

  AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(wr_all_n) && $past(lane_en_n)) |-> (lane_stb == '0)); // R3

  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst) (|lane_stb) |-> !q_drive); // R7

  AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst) (lane_stb == '0) |-> q_drive); // R6

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (lane_stb == '0 && q_drive)); // R8

endmodule

bind lane_write_sram lws_checker #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_all_n (wr_all_n),
  .lane_en_n(lane_en_n),
  .lane_wr_n(lane_wr_n),
  .lane_stb (lane_stb),
  .q_drive  (q_drive)
);

// File: tb/lane_write_sram_tb_top.sv
module lane_write_sram_tb_top;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_all_n = 1'b1;
  logic          lane_en_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic          q_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [1 << AW];

  always #4 clk = ~clk;

  lane_write_sram #(.ADDR_W(AW), .NUM_LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_all_n(wr_all_n),
    .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .d_in(d_in),
    .q_out(q_out), .q_drive(q_drive)
  );

  function automatic logic [DW-1:0] pat(input int k);
    logic [31:0] h;
    h = 32'(k) * 32'h9E3779B9 + 32'h1357_2468;
    return {h[3:0] ^ 4'(k), h};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at current falling edge, return at next falling edge
  task automatic cyc(input logic [AW-1:0] a, input logic g, input logic e,
                     input logic [NL-1:0] b, input logic [DW-1:0] d);
    addr = a; wr_all_n = g; lane_en_n = e; lane_wr_n = b; d_in = d;
    @(negedge clk);
  endtask

  task automatic do_write(input string req, input logic [AW-1:0] a, input logic g,
                          input logic e, input logic [NL-1:0] b, input logic [DW-1:0] d);
    logic [NL-1:0] m;
    if (!g) m = '1;
    else if (!e) m = ~b;
    else m = '0;
    cyc(a, g, e, b, d);
    check({req, " R7 drive"}, DW'(q_drive), DW'(m == '0));
    for (int i = 0; i < NL; i++)
      if (m[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a);
    cyc(a, 1'b1, 1'b1, '1, pat(999));
    check({req, " R6 data"}, q_out, model[a]);
    check({req, " R6 drive"}, DW'(q_drive), DW'(1));
  endtask

  task automatic t_global_fill();
    for (int k = 0; k < 8; k++) do_write("R2 fill", AW'(k), 1'b0, 1'b1, '1, pat(k));
    for (int k = 0; k < 8; k++) do_read("R2 fill readback", AW'(k));
  endtask

  task automatic t_global_override();
    do_write("R2 override", 6'd10, 1'b0, 1'b0, 4'b1111, pat(20));
    do_read("R2 override readback", 6'd10);
    do_write("R2 override2", 6'd10, 1'b0, 1'b1, 4'b0101, pat(21));
    do_read("R2 override2 readback", 6'd10);
  endtask

  task automatic t_single_lanes();
    for (int i = 0; i < NL; i++) begin
      do_write("R1 lane", 6'd12, 1'b0, 1'b1, '1, pat(30));
      do_write("R1 lane", 6'd12, 1'b1, 1'b0, ~(NL'(1) << i), pat(40 + i));
      do_read("R1 single lane", 6'd12);
    end
  endtask

  task automatic t_multi_lanes();
    do_write("R4 base", 6'd14, 1'b0, 1'b1, '1, pat(50));
    do_write("R4 lanes0_2", 6'd14, 1'b1, 1'b0, 4'b1010, pat(51));
    do_read("R4 lanes0_2", 6'd14);
    do_write("R4 lanes1_2_3", 6'd14, 1'b1, 1'b0, 4'b0001, pat(52));
    do_read("R4 lanes1_2_3", 6'd14);
    do_write("R4 all four", 6'd14, 1'b1, 1'b0, 4'b0000, pat(53));
    do_read("R4 all four", 6'd14);
  endtask

  task automatic t_no_enable();
    do_write("R3 base", 6'd16, 1'b0, 1'b1, '1, pat(60));
    do_write("R3 enable high", 6'd16, 1'b1, 1'b1, 4'b0000, pat(61));
    do_read("R3 unchanged", 6'd16);
    do_write("R3 no lanes", 6'd16, 1'b1, 1'b0, 4'b1111, pat(62));
    do_read("R3 unchanged2", 6'd16);
  endtask

  task automatic t_back_to_back();
    do_write("R5 first", 6'd20, 1'b0, 1'b1, '1, pat(70));
    do_write("R5 second", 6'd21, 1'b0, 1'b1, '1, pat(71));
    do_read("R5 immediate", 6'd21);
    do_read("R5 older", 6'd20);
    for (int k = 0; k < 4; k++) do_read("R6 sweep", AW'(k * 2));
  endtask

  task automatic t_reset_hold();
    do_write("R8 pre", 6'd9, 1'b0, 1'b1, '1, pat(80));
    rst = 1'b1;
    addr = 6'd9; wr_all_n = 1'b0; lane_en_n = 1'b0; lane_wr_n = '0; d_in = pat(81);
    @(negedge clk);
    check("R8 drive in reset", DW'(q_drive), DW'(1));
    @(negedge clk);
    rst = 1'b0;
    do_read("R8 content kept", 6'd9);
  endtask

  initial begin
    wr_all_n = 1'b0; lane_en_n = 1'b0; lane_wr_n = '0; d_in = pat(1); addr = 6'd5;
    repeat (3) @(negedge clk);
    check("R8 drive after reset", DW'(q_drive), DW'(1));
    rst = 1'b0;
    wr_all_n = 1'b1; lane_en_n = 1'b1; lane_wr_n = '1;
    @(negedge clk);
    check("R8 idle after reset", DW'(q_drive), DW'(1));
    t_global_fill();
    t_global_override();
    t_single_lanes();
    t_multi_lanes();
    t_no_enable();
    t_back_to_back();
    t_reset_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule